// File: doc/BRIEF.md
# Complementary-Counter Control-Flow Monitor

This block watches control-flow events reported by a sequencer or processor and checks that each monitored procedure ran through its full life cycle: called at the call site, entered, exited and returned to the caller. It holds two counters that start as bitwise complements. Each event carries a label value and one of four event types, and it changes exactly one of the two counters. The pair only becomes complementary again once all four steps of a procedure have been seen.

A checkpoint request compares the pair against each other and against an expected accumulated value supplied with the request. Any disagreement sets a fault flag. The flag stays set until reset. Software that wants to start a fresh accounting window may clear the pair, but only while no fault is latched.

Top module: `cfm_monitor`

## Requirements
- R1: After reset the primary counter reads 0, the inverse counter reads all ones, and the fault output is 0.
- R2: An event with type code 0 (call) or code 2 (exit) adds its label to the primary counter, modulo 2^WIDTH, one cycle later, and leaves the inverse counter unchanged.
- R3: An event with type code 1 (entry) or code 3 (return) subtracts its label from the inverse counter, modulo 2^WIDTH, one cycle later, and leaves the primary counter unchanged.
- R4: After a complete call, entry, exit and return sequence, including nested sequences and sums that wrap past 2^WIDTH, the primary counter is the exact bitwise complement of the inverse counter.
- R5: A checkpoint sets the fault output on the next cycle when the primary counter is not the bitwise complement of the inverse counter.
- R6: A checkpoint sets the fault output on the next cycle when the primary counter differs from the expected value given with the request. A consistent checkpoint leaves the fault output at 0.
- R7: When an event and a checkpoint arrive in the same cycle, the checkpoint judges the counter values from before that event.
- R8: Once set, the fault output stays 1 until reset, whatever later checkpoints observe.
- R9: A clear request returns the pair to 0 and all ones when no fault is latched. While a fault is latched, a clear request leaves both counters unchanged.
- R10: When a clear request is accepted in the same cycle as an event, the clear wins and the event is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| evtValid | input | 1 | An event is reported this cycle |
| evtType | input | 2 | Event type: 0 call, 1 entry, 2 exit, 3 return |
| evtLabel | input | WIDTH | Label value carried by the event |
| chkReq | input | 1 | Checkpoint request |
| chkExpect | input | WIDTH | Expected primary counter value at the checkpoint |
| clrReq | input | 1 | Request to clear the counter pair |
| cntPrim | output | WIDTH | Primary counter |
| cntInv | output | WIDTH | Inverse counter |
| fault | output | 1 | Latched control-flow fault |

## Verification
The bench builds the block with WIDTH at its default of 32. At that width the all-ones reset value is the full 0xFFFFFFFF, and a call-site label near the top of the range makes the accumulated sum wrap. This shows that the complement relation survives modular overflow on both counters. Fault cases are each entered from a fresh reset, so that stickiness and the refused clear are observed separately from the event that raised the fault.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  typedef enum logic [1:0] {
    EV_CALL   = 2'd0,
    EV_ENTRY  = 2'd1,
    EV_EXIT   = 2'd2,
    EV_RETURN = 2'd3
  } flowEvt_e;

  typedef struct packed {
    logic addPrim;
    logic subInv;
    logic clear;
    logic check;
  } cntStrb_t;
endpackage

// File: rtl/cfm_ctrl.sv
module cfm_ctrl
  import cfm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evtValid,
  input  logic [1:0] evtType,
  input  logic       chkReq,
  input  logic       clrReq,
  input  logic       mismatch,
  output cntStrb_t   strb,
  output logic       fault
);
  logic faultQ;
  flowEvt_e evtKind;

  assign evtKind = flowEvt_e'(evtType);

  always_comb begin
    strb       = '0;
    strb.check = chkReq;
    strb.clear = clrReq && !faultQ;
    if (evtValid && !strb.clear) begin
      unique case (evtKind)
        EV_CALL, EV_EXIT:    strb.addPrim = 1'b1;
        EV_ENTRY, EV_RETURN: strb.subInv  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       faultQ <= 1'b0;
    else if (strb.check && mismatch) faultQ <= 1'b1;
  end

  assign fault = faultQ;

  // R8: a latched fault never drops without reset
  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    faultQ |=> faultQ);

  // R2/R3: an event moves at most one counter
  a_r2_one_counter: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.addPrim && strb.subInv));
endmodule

// File: rtl/cfm_dpath.sv
module cfm_dpath
  import cfm_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrb_t         strb,
  input  logic [WIDTH-1:0] label,
  input  logic [WIDTH-1:0] expect_,
  output logic [WIDTH-1:0] cntPrim,
  output logic [WIDTH-1:0] cntInv,
  output logic             mismatch
);
  localparam logic [WIDTH-1:0] PRIM_INIT = '0;
  localparam logic [WIDTH-1:0] INV_INIT  = {WIDTH{1'b1}};

  logic [WIDTH-1:0] primQ, invQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primQ <= PRIM_INIT;
      invQ  <= INV_INIT;
    end else if (strb.clear) begin
      primQ <= PRIM_INIT;
      invQ  <= INV_INIT;
    end else begin
      if (strb.addPrim) primQ <= primQ + label;
      if (strb.subInv)  invQ  <= invQ - label;
    end
  end

  assign cntPrim  = primQ;
  assign cntInv   = invQ;
  assign mismatch = (primQ != ~invQ) || (primQ != expect_);

  // R2: adding on the primary side leaves the inverse side alone
  a_r2_inv_untouched: assert property (@(posedge clk) disable iff (!rstN)
    strb.addPrim |=> $stable(invQ));

  // R3: subtracting on the inverse side leaves the primary side alone
  a_r3_prim_untouched: assert property (@(posedge clk) disable iff (!rstN)
    strb.subInv |=> $stable(primQ));

  // R9/R10: an accepted clear restores the initial pair
  a_r10_clear_restores: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (primQ == PRIM_INIT) && (invQ == INV_INIT));
endmodule

// File: rtl/cfm_monitor.sv
module cfm_monitor
  import cfm_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtValid,
  input  logic [1:0]       evtType,
  input  logic [WIDTH-1:0] evtLabel,
  input  logic             chkReq,
  input  logic [WIDTH-1:0] chkExpect,
  input  logic             clrReq,
  output logic [WIDTH-1:0] cntPrim,
  output logic [WIDTH-1:0] cntInv,
  output logic             fault
);
  cntStrb_t strb;
  logic     mismatch;

  cfm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .evtValid (evtValid),
    .evtType  (evtType),
    .chkReq   (chkReq),
    .clrReq   (clrReq),
    .mismatch (mismatch),
    .strb     (strb),
    .fault    (fault)
  );

  cfm_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .label    (evtLabel),
    .expect_  (chkExpect),
    .cntPrim  (cntPrim),
    .cntInv   (cntInv),
    .mismatch (mismatch)
  );

  // R5/R6: an inconsistent checkpoint at the ports raises the fault
  a_r5_bad_check_faults: assert property (@(posedge clk) disable iff (!rstN)
    chkReq && ((cntPrim != ~cntInv) || (cntPrim != chkExpect)) |=> fault);

  // R9: a clear while faulted, with no event, freezes the pair
  a_r9_clear_refused: assert property (@(posedge clk) disable iff (!rstN)
    fault && clrReq && !evtValid |=> $stable(cntPrim) && $stable(cntInv));
endmodule

// File: tb/sim_cfm_monitor.sv
module sim_cfm_monitor;
  localparam int W = 32;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 1'b0;
  logic [1:0] evtType = 2'd0;
  logic [W-1:0] evtLabel = '0;
  logic chkReq = 1'b0;
  logic [W-1:0] chkExpect = '0;
  logic clrReq = 1'b0;
  logic [W-1:0] cntPrim, cntInv;
  logic fault;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfm_monitor #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtType(evtType),
    .evtLabel(evtLabel), .chkReq(chkReq), .chkExpect(chkExpect),
    .clrReq(clrReq), .cntPrim(cntPrim), .cntInv(cntInv), .fault(fault)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // one cycle of stimulus; returns at the next falling edge
  task automatic cyc(input bit ev, input logic [1:0] ty, input logic [W-1:0] lb,
                     input bit ck, input logic [W-1:0] ex, input bit cl);
    evtValid = ev; evtType = ty; evtLabel = lb;
    chkReq = ck; chkExpect = ex; clrReq = cl;
    @(negedge clk);
    evtValid = 1'b0; chkReq = 1'b0; clrReq = 1'b0;
  endtask

  task automatic evt(input logic [1:0] ty, input logic [W-1:0] lb);
    cyc(1'b1, ty, lb, 1'b0, '0, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    check(cntPrim == '0, "R1 prim", cntPrim, '0);
    check(cntInv == ONES, "R1 inv", cntInv, ONES);
    check(fault == 1'b0, "R1 fault", {31'd0, fault}, '0);
  endtask

  task automatic t_basic();
    evt(2'd0, 5);
    check(cntPrim == 5 && cntInv == ONES, "R2 call", cntPrim, 5);
    evt(2'd1, 7);
    check(cntInv == ~32'd7 && cntPrim == 5, "R3 entry", cntInv, ~32'd7);
    evt(2'd2, 7);
    check(cntPrim == 12 && cntInv == ~32'd7, "R2 exit", cntPrim, 12);
    evt(2'd3, 5);
    check(cntInv == ~32'd12 && cntPrim == 12, "R3 return", cntInv, ~32'd12);
    check(cntPrim == ~cntInv, "R4 complement", cntPrim, ~cntInv);
    cyc(1'b0, 2'd0, '0, 1'b1, 12, 1'b0);
    check(fault == 1'b0, "R6 good check", {31'd0, fault}, '0);
  endtask

  task automatic t_nested();
    evt(2'd0, 3); evt(2'd1, 9);
    evt(2'd0, 4); evt(2'd1, 11); evt(2'd2, 11); evt(2'd3, 4);
    evt(2'd2, 9); evt(2'd3, 3);
    check(cntPrim == 39 && cntInv == ~32'd39, "R4 nested", cntPrim, 39);
    cyc(1'b0, 2'd0, '0, 1'b1, 39, 1'b0);
    check(fault == 1'b0, "R6 nested check", {31'd0, fault}, '0);
  endtask

  task automatic t_same_cycle();
    cyc(1'b1, 2'd0, 5, 1'b1, 39, 1'b0);
    check(fault == 1'b0, "R7 pre-update sample", {31'd0, fault}, '0);
    check(cntPrim == 44, "R7 event applied", cntPrim, 44);
    evt(2'd1, 7); evt(2'd2, 7); evt(2'd3, 5);
    check(cntPrim == 51 && cntInv == ~32'd51, "R4 after R7", cntPrim, 51);
  endtask

  task automatic t_wrap();
    do_reset();
    evt(2'd0, 32'hFFFF_FFF0); evt(2'd1, 32'h20);
    evt(2'd2, 32'h20); evt(2'd3, 32'hFFFF_FFF0);
    check(cntPrim == 32'h10 && cntInv == ~32'h10, "R4 wrap", cntPrim, 32'h10);
    cyc(1'b0, 2'd0, '0, 1'b1, 32'h10, 1'b0);
    check(fault == 1'b0, "R6 wrap check", {31'd0, fault}, '0);
  endtask

  task automatic t_clear();
    cyc(1'b0, 2'd0, '0, 1'b0, '0, 1'b1);
    check(cntPrim == '0 && cntInv == ONES, "R9 clear", cntPrim, '0);
    evt(2'd0, 6);
    cyc(1'b1, 2'd2, 8, 1'b0, '0, 1'b1);
    check(cntPrim == '0 && cntInv == ONES, "R10 clear wins", cntPrim, '0);
  endtask

  task automatic t_bad_expect();
    do_reset();
    cyc(1'b0, 2'd0, '0, 1'b1, 1, 1'b0);
    check(fault == 1'b1, "R6 wrong expect", {31'd0, fault}, 1);
  endtask

  task automatic t_bad_pair();
    do_reset();
    evt(2'd0, 5);
    cyc(1'b0, 2'd0, '0, 1'b1, 5, 1'b0);
    check(fault == 1'b1, "R5 not complementary", {31'd0, fault}, 1);
    evt(2'd1, 5);
    cyc(1'b0, 2'd0, '0, 1'b1, 5, 1'b0);
    check(fault == 1'b1, "R8 sticky", {31'd0, fault}, 1);
    cyc(1'b0, 2'd0, '0, 1'b0, '0, 1'b1);
    check(cntPrim == 5, "R9 clear refused prim", cntPrim, 5);
    check(cntInv == ~32'd5, "R9 clear refused inv", cntInv, ~32'd5);
    check(fault == 1'b1, "R8 after clear", {31'd0, fault}, 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_nested();
    t_same_cycle();
    t_wrap();
    t_clear();
    t_bad_expect();
    t_bad_pair();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule